// File: doc/BRIEF.md
# Not-Recently-Used Replacement Selector for One TLB Set

This block holds the replacement state for a single TLB set of `NUM_WAYS` entries. Each entry owns one used flag. The flag is raised when the entry is read on a hit or written by a fill. When every flag in the set is up, the whole set is wiped on the next clock edge. The entries touched in that same cycle are the only ones that stay marked.

When a lookup misses, the block offers a one-hot victim along with its binary index. The victim is the lowest-numbered entry whose flag is down, and it is produced combinationally in the same cycle as the miss. A software refill handler or a hardware refill path then writes the new translation at that entry. A fill may instead name a way of its own choice, which overrides the offered victim. The full flag vector can be read at all times, so software can track the replacement state exactly.

Top module: `nru_victim_sel`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every used flag, so `used_bits` reads all zeros after reset.
- R2: With `hit_valid` high at a rising edge, flag `hit_way` is 1 after that edge.
- R3: With `fill_valid` high at a rising edge, the flag of the fill target is 1 after that edge.
- R4: If `used_bits` is all ones at a rising edge, then after that edge only the flags set by that cycle's hit or fill are 1, and all the others are 0.
- R5: While `miss` is high, `victim_oh` is one-hot in the same cycle and marks the lowest index whose flag is 0. While `miss` is low, `victim_oh` is all zeros.
- R6: While `used_bits` is all ones, the victim offered is entry 0.
- R7: With `fill_force` high, the fill target is `fill_way` (a binary way index starting at 0). With `fill_force` low, the fill target is the victim index that the find-first pick computes from the current flags, whether or not `miss` is high.
- R8: `victim_idx` is the binary index of the set bit in `victim_oh` while `miss` is high, and `used_bits` always shows the current flag vector.
- R9: While the flags are not all ones, no flag goes from 1 to 0 except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_valid | input | 1 | A lookup hit one entry this cycle |
| hit_way | input | IDX_W | Index of the entry that hit |
| fill_valid | input | 1 | A new translation is written this cycle |
| fill_force | input | 1 | The fill uses `fill_way` and not the offered victim |
| fill_way | input | IDX_W | Way chosen by software for a forced fill |
| miss | input | 1 | A lookup missed and a victim is requested |
| victim_oh | output | NUM_WAYS | One-hot victim, zero when no miss |
| victim_idx | output | IDX_W | Binary index of the victim |
| used_bits | output | NUM_WAYS | Readback of the used-flag vector |

## Verification
The bench builds the block with `NUM_WAYS = 4`, so the set has only sixteen flag states. It puts the block into each of these sixteen states from reset. From each state it applies every hit option (none, or any one of the four ways) combined with every fill option (none, an automatic fill, or a forced fill to each of the four ways). This reaches the all-ones wipe from every combination of same-cycle marks, including hit and fill landing on the same entry. It also reaches every find-first position, including the fallback to entry 0 when the set is full.

// File: rtl/nru_pkg.sv
// Package: shared types for the NRU replacement selector.
// Assumes: nothing beyond a one-bit choice of fill source.
package nru_pkg;
    typedef enum logic {
        FILL_AUTO   = 1'b0,
        FILL_FORCED = 1'b1
    } fill_src_e;
endpackage

// File: rtl/nru_find_first.sv
// Module: nru_find_first
// Picks the lowest index whose used flag is 0. It returns the pick as a
// one-hot vector and as a binary index.
// Assumes: all-ones input gives a zero one-hot vector and index 0. The
// caller masks that case.
module nru_find_first #(
    parameter int NUM_WAYS = 4,
    localparam int IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] flags,
    output logic [NUM_WAYS-1:0] pick_oh,
    output logic [IDX_W-1:0]    pick_idx
);
    logic [NUM_WAYS:0] free_below;

    assign free_below[0] = 1'b0;

    // Priority chain: an entry wins if it is free and no lower entry is free.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_chain
        assign pick_oh[g]      = ~flags[g] & ~free_below[g];
        assign free_below[g+1] = free_below[g] | ~flags[g];
    end

    // One-hot to binary encoder.
    always_comb begin
        pick_idx = '0;
        for (int i = 0; i < NUM_WAYS; i++) begin
            if (pick_oh[i]) pick_idx = pick_idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/nru_set_mask.sv
// Module: nru_set_mask
// Turns the hit index and the fill index of this cycle into one mask of
// entries to mark as used.
// Assumes: both indices are below NUM_WAYS. Hit and fill may name the same
// entry.
module nru_set_mask #(
    parameter int NUM_WAYS = 4,
    localparam int IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                hit_valid,
    input  logic [IDX_W-1:0]    hit_way,
    input  logic                fill_valid,
    input  logic [IDX_W-1:0]    fill_target,
    output logic [NUM_WAYS-1:0] mark
);
    // Per-entry decode of both access sources.
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_dec
        assign mark[g] = (hit_valid  && (hit_way     == IDX_W'(g))) ||
                         (fill_valid && (fill_target == IDX_W'(g)));
    end
endmodule

// File: rtl/nru_used_reg.sv
// Module: nru_used_reg
// Holds the used flags. It ORs in this cycle's marks. When the flags are
// all ones it wipes them, keeping only this cycle's marks.
// Assumes: synchronous active-low reset.
module nru_used_reg #(
    parameter int NUM_WAYS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAYS-1:0] mark,
    output logic [NUM_WAYS-1:0] used,
    output logic                all_set
);
    logic [NUM_WAYS-1:0] used_q;
    logic [NUM_WAYS-1:0] used_d;

    assign all_set = &used_q;
    assign used    = used_q;

    // Next state: the wipe wins over old flags but never over new marks.
    always_comb begin
        if (all_set) used_d = mark;
        else         used_d = used_q | mark;
    end

    // Flag register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end

    // R2/R3: every entry marked in a cycle is set after the edge.
    p_mark_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mark != '0) |=> ((used_q & $past(mark)) == $past(mark)));

    // R4: a full set keeps only the marks of the wipe cycle.
    p_full_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&used_q) |=> (used_q == $past(mark)));

    // R9: flags never drop while the set is not full.
    p_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(&used_q) |=> ((used_q & $past(used_q)) == $past(used_q)));
endmodule

// File: rtl/nru_victim_sel.sv
// Module: nru_victim_sel
// NRU replacement selector for one TLB set. It tracks the used flags,
// offers a find-first victim on a miss, and marks entries on hits and fills.
// Assumes: at most one hit and one fill per cycle. The offered victim is
// valid while the miss input is high.
module nru_victim_sel #(
    parameter int NUM_WAYS = 4,
    localparam int IDX_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_valid,
    input  logic [IDX_W-1:0]    hit_way,
    input  logic                fill_valid,
    input  logic                fill_force,
    input  logic [IDX_W-1:0]    fill_way,
    input  logic                miss,
    output logic [NUM_WAYS-1:0] victim_oh,
    output logic [IDX_W-1:0]    victim_idx,
    output logic [NUM_WAYS-1:0] used_bits
);
    import nru_pkg::*;

    logic [NUM_WAYS-1:0] used_w;
    logic                full_w;
    logic [NUM_WAYS-1:0] eff_flags;
    logic [NUM_WAYS-1:0] pick_oh;
    logic [IDX_W-1:0]    pick_idx;
    logic [IDX_W-1:0]    fill_target;
    logic [NUM_WAYS-1:0] mark;
    fill_src_e           fill_src;

    // A full set is seen as already wiped, so the pick falls to entry 0.
    assign eff_flags = full_w ? '0 : used_w;
    assign fill_src  = fill_force ? FILL_FORCED : FILL_AUTO;

    // Choose where a fill lands.
    always_comb begin
        if (fill_src == FILL_FORCED) fill_target = fill_way;
        else                         fill_target = pick_idx;
    end

    nru_find_first #(.NUM_WAYS(NUM_WAYS)) ff_i (
        .flags    (eff_flags),
        .pick_oh  (pick_oh),
        .pick_idx (pick_idx)
    );

    nru_set_mask #(.NUM_WAYS(NUM_WAYS)) mask_i (
        .hit_valid   (hit_valid),
        .hit_way     (hit_way),
        .fill_valid  (fill_valid),
        .fill_target (fill_target),
        .mark        (mark)
    );

    nru_used_reg #(.NUM_WAYS(NUM_WAYS)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark    (mark),
        .used    (used_w),
        .all_set (full_w)
    );

    // Output drive: the victim is shown only during a miss.
    assign victim_oh  = miss ? pick_oh : '0;
    assign victim_idx = pick_idx;
    assign used_bits  = used_w;

    // R5: a miss always gets exactly one victim.
    p_one_victim_r5: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> ($countones(victim_oh) == 1));

    // R5: the victim is a free entry unless the set is full.
    p_victim_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !(&used_bits)) |-> ((victim_oh & used_bits) == '0));

    // R6: a full set offers entry 0.
    p_full_pick_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && (&used_bits)) |-> (victim_oh[0] && victim_idx == '0));

    // R7: a forced fill marks the named way.
    p_forced_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_force) |=> used_bits[$past(fill_way)]);
endmodule

// File: tb/nru_victim_sel_tb_top.sv
// Bench: builds each 4-entry flag state from reset, then applies every
// hit option combined with every fill option. Results are compared with an
// arithmetic model.
module nru_victim_sel_tb_top;
    localparam int NW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_valid = 1'b0;
    logic [IW-1:0] hit_way = '0;
    logic          fill_valid = 1'b0;
    logic          fill_force = 1'b0;
    logic [IW-1:0] fill_way = '0;
    logic          miss = 1'b0;
    logic [NW-1:0] victim_oh;
    logic [IW-1:0] victim_idx;
    logic [NW-1:0] used_bits;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    nru_victim_sel #(.NUM_WAYS(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
        .fill_valid(fill_valid), .fill_force(fill_force), .fill_way(fill_way),
        .miss(miss), .victim_oh(victim_oh), .victim_idx(victim_idx),
        .used_bits(used_bits)
    );

    // Watchdog: counts cycles and ends a hung run as a failure.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_bad = n_bad + 1;
            n_chk = n_chk + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected victim index: lowest zero bit, or entry 0 when full.
    function automatic int exp_vic(input int s);
        if (s == 15) return 0;
        for (int i = 0; i < NW; i++) if (((s >> i) & 1) == 0) return i;
        return 0;
    endfunction

    task automatic build_state(input int s);
        @(negedge clk);
        rst_n = 1'b0;
        hit_valid = 1'b0; fill_valid = 1'b0; miss = 1'b0; fill_force = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        if (s == 0) chk("R1 reset clears flags", int'(used_bits), 0);
        for (int i = 0; i < NW; i++) begin
            if (((s >> i) & 1) != 0) begin
                hit_valid = 1'b1; hit_way = IW'(i);
                @(negedge clk);
            end
        end
        hit_valid = 1'b0;
        chk("R2 hits build state", int'(used_bits), s);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        for (int s = 0; s < 16; s++) begin
            for (int h = 0; h < 5; h++) begin
                for (int f = 0; f < 6; f++) begin
                    int v;
                    int tgt;
                    int mk;
                    int nxt;
                    build_state(s);
                    v = exp_vic(s);
                    #1;
                    chk("R5 no miss gives zero victim", int'(victim_oh), 0);
                    miss = 1'b1;
                    #1;
                    chk(s == 15 ? "R6 full set picks entry 0" : "R5 find-first victim",
                        int'(victim_oh), 1 << v);
                    chk("R8 victim index", int'(victim_idx), v);
                    chk("R8 readback", int'(used_bits), s);
                    miss = 1'b0;
                    mk = 0;
                    if (h < 4) begin
                        hit_valid = 1'b1; hit_way = IW'(h); mk |= 1 << h;
                    end
                    if (f == 1) begin
                        fill_valid = 1'b1; fill_force = 1'b0; tgt = v; mk |= 1 << tgt;
                    end else if (f >= 2) begin
                        fill_valid = 1'b1; fill_force = 1'b1; fill_way = IW'(f - 2);
                        tgt = f - 2; mk |= 1 << tgt;
                    end
                    nxt = (s == 15) ? mk : (s | mk);
                    @(negedge clk);
                    hit_valid = 1'b0; fill_valid = 1'b0; fill_force = 1'b0;
                    if (s == 15)      chk("R4 full wipe keeps marks", int'(used_bits), nxt);
                    else if (f >= 2)  chk("R7 forced fill", int'(used_bits), nxt);
                    else if (f == 1)  chk("R3 auto fill", int'(used_bits), nxt);
                    else              chk("R9 flags kept", int'(used_bits), nxt);
                end
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule